// File: doc/BRIEF.md
# Floating-Point Multiply Coprocessor

A register-mapped single-precision multiplier that a processor drives over a plain read/write bus. Software loads the two operands, writes a command word to start the operation, polls a status word until its ready bit comes back, and then fetches the product. Every command takes the same number of clocks whatever the operands are, so the polling loop has a fixed, known length.

Inside, a shift-and-add engine multiplies the two 24-bit significands, one partial product per clock. A final stage then renormalises the product, rebiases the exponent and handles the special values. Zero, infinity and NaN follow the usual single-precision encodings. Inputs with a zero exponent field count as zero, and rounding is by truncation. Only one command code multiplies. Any other code finishes after the same delay with the canonical quiet NaN as its result.

Top module: `fpm_copro`

## Requirements
- R1: Address map (addr_i): 0 = operand A, 1 = operand B, 2 = command on write / status on read, 3 = result (read only). Operands A and B read back as written. A write to address 3 has no effect. rdata_o is registered and shows, one clock after the edge that samples re_i, the value the addressed register held before that edge.
- R2: After reset the status word reads 0x00000001 (bit 0 = ready, all other bits zero) and the result reads 0x00000000.
- R3: A command write while ready starts an operation and clears ready at that same edge. The command code is wdata_i[3:0], and code 1 means multiply.
- R4: Ready is set again at the 25th rising edge after the edge that accepted the command, for every operand value and every code.
- R5: For normal operands the result sign is the XOR of the operand signs. The biased exponent is expA + expB − 127, plus one when the significand product is at least 2. The 23 fraction bits are the product bits just below its leading 1, truncated.
- R6: A biased result exponent of 255 or more gives infinity with the XOR sign. A biased exponent of 0 or below gives zero with the XOR sign.
- R7: An operand whose exponent field is 0 (zero or subnormal), multiplied by a finite value, gives zero with the XOR sign.
- R8: Infinity times a nonzero non-NaN value gives infinity with the XOR sign.
- R9: A NaN operand, or zero times infinity, gives 0x7FC00000.
- R10: A command code other than 1 gives 0x7FC00000 after the same delay as a multiply.
- R11: A command write while ready is clear is ignored. It neither restarts nor shortens the running operation, and it does not change its result.
- R12: Reading the result while ready is clear returns the previous operation's result.
- R13: Operands are captured when the command is accepted. Writing A or B during an operation changes the register readback but not the running product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |

## Verification
The assertions check the handshake on every cycle. Ready drops on an accepted command and returns exactly 25 clocks later. A command issued while busy leaves ready low. The held result does not move while busy. The final product of a normal multiply always has a leading one in one of its top two bits. Unknown codes always resolve to the quiet NaN. The arithmetic itself can only be shown by the bench's scenarios: the exponent sums, truncation, overflow and underflow boundaries, and the special-value ordering, checked against a behavioural model. The same applies to operand capture and to stale reads during an operation, which depend on when the writes and reads fall.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int DATA_W  = 1 + EXP_W + FRAC_W;
  localparam int MANT_W  = FRAC_W + 1;
  localparam int PROD_W  = 2 * MANT_W;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam int OP_W    = 4;
  localparam int ADDR_W  = 2;
  localparam int LAT     = MANT_W + 1;

  localparam logic [OP_W-1:0]   OP_MUL    = OP_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_OPA  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_OPB  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_CMD  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADDR_RES  = ADDR_W'(3);

  localparam logic [DATA_W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [FRAC_W-1:0] frac;
  } fp_t;

  typedef struct packed {
    logic zero;
    logic inf;
    logic nan;
  } fp_class_t;
endpackage

// File: rtl/fpm_classify.sv
module fpm_classify
  import fpm_pkg::*;
(
  input  logic [DATA_W-1:0] val_i,
  output fp_class_t         cls_o,
  output logic              sign_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [MANT_W-1:0] mant_o
);
  fp_t  f;
  logic exp_ones, exp_zero, frac_nz;

  assign f        = fp_t'(val_i);
  assign exp_ones = &f.exp;
  assign exp_zero = ~|f.exp;
  assign frac_nz  = |f.frac;

  // subnormals flush to zero
  assign cls_o.zero = exp_zero;
  assign cls_o.inf  = exp_ones & ~frac_nz;
  assign cls_o.nan  = exp_ones & frac_nz;
  assign sign_o     = f.sign;
  assign exp_o      = f.exp;
  assign mant_o     = {~exp_zero, f.frac};
endmodule

// File: rtl/fpm_pack.sv
module fpm_pack
  import fpm_pkg::*;
(
  input  logic [PROD_W-1:0] prod_i,
  input  logic [EXP_W:0]    esum_i,
  input  logic              sign_i,
  input  fp_class_t         cls_a_i,
  input  fp_class_t         cls_b_i,
  input  logic              op_mul_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int EW = EXP_W + 2;
  localparam logic signed [EW-1:0] BIAS_S = EW'(BIAS);
  localparam logic signed [EW-1:0] EMAX_S = EW'(EXP_MAX);

  logic              lead;
  logic [FRAC_W-1:0] frac;
  logic signed [EW-1:0] e;
  logic any_nan, zero_inf, any_inf, any_zero;

  always_comb begin
    lead     = prod_i[PROD_W-1];
    frac     = lead ? prod_i[PROD_W-2 -: FRAC_W] : prod_i[PROD_W-3 -: FRAC_W];
    e        = $signed({1'b0, esum_i}) - BIAS_S + $signed({{(EW-1){1'b0}}, lead});
    any_nan  = cls_a_i.nan | cls_b_i.nan;
    zero_inf = (cls_a_i.zero & cls_b_i.inf) | (cls_a_i.inf & cls_b_i.zero);
    any_inf  = cls_a_i.inf | cls_b_i.inf;
    any_zero = cls_a_i.zero | cls_b_i.zero;

    if (!op_mul_i || any_nan || zero_inf)
      res_o = QNAN;
    else if (any_inf)
      res_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (any_zero)
      res_o = {sign_i, {(DATA_W-1){1'b0}}};
    else if (e >= EMAX_S)
      res_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (e <= 0)
      res_o = {sign_i, {(DATA_W-1){1'b0}}};
    else
      res_o = {sign_i, e[EXP_W-1:0], frac};
  end

  // R9: every NaN leaving the block is the canonical quiet NaN
  always_comb begin
    p_nan_canonical_r9: assert (!((&res_o[DATA_W-2 -: EXP_W]) && (|res_o[FRAC_W-1:0]))
                                || res_o == QNAN);
  end
endmodule

// File: rtl/fpm_mul_core.sv
module fpm_mul_core
  import fpm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [OP_W-1:0]   op_i,
  output logic              done_o,
  output logic [DATA_W-1:0] res_o
);
  localparam int CNT_W = $clog2(MANT_W);

  logic [DATA_W-1:0] opnd   [2];
  fp_class_t         cls    [2];
  logic              sgn    [2];
  logic [EXP_W-1:0]  expo   [2];
  logic [MANT_W-1:0] mant   [2];

  assign opnd[0] = a_i;
  assign opnd[1] = b_i;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fpm_classify u_cls (
      .val_i  (opnd[i]),
      .cls_o  (cls[i]),
      .sign_o (sgn[i]),
      .exp_o  (expo[i]),
      .mant_o (mant[i])
    );
  end

  fp_class_t         cls_a_q, cls_b_q;
  logic              sign_q, op_mul_q, iter_q, pack_q;
  logic [EXP_W:0]    esum_q;
  logic [MANT_W-1:0] mcand_q, hi_q, lo_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [MANT_W:0]   sum;

  assign sum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mcand_q} : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cls_a_q  <= '0;
      cls_b_q  <= '0;
      sign_q   <= 1'b0;
      op_mul_q <= 1'b0;
      iter_q   <= 1'b0;
      pack_q   <= 1'b0;
      esum_q   <= '0;
      mcand_q  <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
      cnt_q    <= '0;
    end else begin
      pack_q <= 1'b0;
      if (start_i) begin
        cls_a_q  <= cls[0];
        cls_b_q  <= cls[1];
        sign_q   <= sgn[0] ^ sgn[1];
        op_mul_q <= (op_i == OP_MUL);
        esum_q   <= {1'b0, expo[0]} + {1'b0, expo[1]};
        mcand_q  <= mant[0];
        lo_q     <= mant[1];
        hi_q     <= '0;
        cnt_q    <= '0;
        iter_q   <= 1'b1;
      end else if (iter_q) begin
        // one partial product per clock, fixed count
        hi_q  <= sum[MANT_W:1];
        lo_q  <= {sum[0], lo_q[MANT_W-1:1]};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(MANT_W-1)) begin
          iter_q <= 1'b0;
          pack_q <= 1'b1;
        end
      end
    end
  end

  fpm_pack u_pack (
    .prod_i   ({hi_q, lo_q}),
    .esum_i   (esum_q),
    .sign_i   (sign_q),
    .cls_a_i  (cls_a_q),
    .cls_b_i  (cls_b_q),
    .op_mul_i (op_mul_q),
    .res_o    (res_o)
  );

  assign done_o = pack_q;

  logic special_q;
  assign special_q = |{cls_a_q, cls_b_q};

  // R5: product of two normal significands lies in [1,4)
  p_lead_one_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pack_q && !special_q) |-> (hi_q[MANT_W-1] | hi_q[MANT_W-2]));

  // R10: non-multiply codes resolve to quiet NaN
  p_badop_nan_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pack_q && !op_mul_q) |-> (res_o == QNAN));

  p_iter_pack_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(iter_q && pack_q));
endmodule

// File: rtl/fpm_copro.sv
module fpm_copro
  import fpm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int LAT_W = $clog2(LAT + 2);

  logic [DATA_W-1:0] op_a_q, op_b_q, result_q, rdata_q, core_res;
  logic              ready_q, start, core_done;
  logic [DATA_W-1:0] rd_mux;

  assign start = we_i && (addr_i == ADDR_CMD) && ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_a_q <= '0;
      op_b_q <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_OPA) op_a_q <= wdata_i;
      if (addr_i == ADDR_OPB) op_b_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q  <= 1'b1;
      result_q <= '0;
    end else if (start) begin
      ready_q  <= 1'b0;
    end else if (core_done) begin
      ready_q  <= 1'b1;
      result_q <= core_res;
    end
  end

  fpm_mul_core u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .a_i     (op_a_q),
    .b_i     (op_b_q),
    .op_i    (wdata_i[OP_W-1:0]),
    .done_o  (core_done),
    .res_o   (core_res)
  );

  always_comb begin
    unique case (addr_i)
      ADDR_OPA: rd_mux = op_a_q;
      ADDR_OPB: rd_mux = op_b_q;
      ADDR_CMD: rd_mux = {{(DATA_W-1){1'b0}}, ready_q};
      default:  rd_mux = result_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  // latency tracker for the fixed-delay check
  logic [LAT_W-1:0] busy_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 busy_cnt <= '0;
    else if (start)                              busy_cnt <= '0;
    else if (!ready_q && busy_cnt != '1)         busy_cnt <= busy_cnt + 1'b1;
  end

  p_start_clears_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !ready_q);

  p_fixed_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_q) |-> (busy_cnt == LAT_W'(LAT)));

  p_done_sets_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_done |=> ready_q);

  p_busy_cmd_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_CMD && !ready_q && !core_done) |=> !ready_q);

  p_result_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_q |=> (ready_q || $stable(result_q)));
endmodule

// File: tb/sim_fpm_copro.sv
module sim_fpm_copro;
  localparam int LATC = 25;
  localparam logic [31:0] QN = 32'h7FC00000;

  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0, re = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  int          checks = 0, fails = 0, cycles = 0;
  string       cur_req = "R2";
  bit          finished = 0;

  always #5 clk = ~clk;

  fpm_copro u0 (.clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re),
                .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata));

  function automatic logic [31:0] ref_mul(logic [31:0] a, logic [31:0] b);
    int     ea = int'(a[30:23]), eb = int'(b[30:23]), e;
    bit     s = a[31] ^ b[31];
    bit     na = (ea == 255) && (a[22:0] != 0), nb = (eb == 255) && (b[22:0] != 0);
    bit     ia = (ea == 255) && (a[22:0] == 0), ib = (eb == 255) && (b[22:0] == 0);
    bit     za = (ea == 0), zb = (eb == 0);
    longint p;
    logic [22:0] f;
    if (na || nb || (za && ib) || (ia && zb)) return QN;
    if (ia || ib) return {s, 8'hFF, 23'h0};
    if (za || zb) return {s, 31'h0};
    p = longint'({1'b1, a[22:0]}) * longint'({1'b1, b[22:0]});
    e = ea + eb - 127;
    if (p[47]) begin e = e + 1; f = p[46:24]; end
    else f = p[45:23];
    if (e >= 255) return {s, 8'hFF, 23'h0};
    if (e <= 0) return {s, 31'h0};
    return {s, e[7:0], f};
  endfunction

  // behavioural reference, updated on the same edges
  logic [31:0] m_a, m_b, m_pa, m_pb, m_res, m_rd;
  logic [3:0]  m_op;
  bit          m_ready;
  int          m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a = 0; m_b = 0; m_res = 0; m_rd = 0; m_ready = 1; m_cnt = 0;
      m_pa = 0; m_pb = 0; m_op = 0;
    end else begin
      if (re) case (addr)
        2'd0: m_rd = m_a;
        2'd1: m_rd = m_b;
        2'd2: m_rd = {31'h0, m_ready};
        default: m_rd = m_res;
      endcase
      if (we && addr == 2'd2 && m_ready) begin
        m_ready = 0; m_cnt = LATC; m_pa = m_a; m_pb = m_b; m_op = wdata[3:0];
      end else if (!m_ready) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_ready = 1;
          m_res = (m_op == 4'd1) ? ref_mul(m_pa, m_pb) : QN;
        end
      end
      if (we && addr == 2'd0) m_a = wdata;
      if (we && addr == 2'd1) m_b = wdata;
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    checks++;
    if (rdata !== m_rd) begin
      fails++;
      $display("FAIL %s model compare: actual %h expected %h", cur_req, rdata, m_rd);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    re = 1; addr = a;
    @(negedge clk);
    d = rdata; re = 0;
  endtask

  task automatic poll(output int n);
    logic [31:0] s;
    n = 0;
    do begin rd(2'd2, s); n++; end while (s[0] == 0 && n < 200);
  endtask

  task automatic run(string req, logic [31:0] a, logic [31:0] b, logic [3:0] op,
                     logic [31:0] exp);
    logic [31:0] r;
    int n;
    cur_req = req;
    wr(2'd0, a); wr(2'd1, b); wr(2'd2, {28'h0, op});
    poll(n);
    chk("R4 latency", 32'(n), 32'(LATC + 1));
    rd(2'd3, r);
    chk(req, r, exp);
  endtask

  initial begin
    logic [31:0] r;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(2'd2, r); chk("R2 reset status", r, 32'h1);
    rd(2'd3, r); chk("R2 reset result", r, 32'h0);

    cur_req = "R1";
    wr(2'd0, 32'h12345678); rd(2'd0, r); chk("R1 readback A", r, 32'h12345678);
    wr(2'd1, 32'hCAFEF00D); rd(2'd1, r); chk("R1 readback B", r, 32'hCAFEF00D);

    run("R5 2*3",        32'h40000000, 32'h40400000, 4'd1, 32'h40C00000);
    run("R5 1.5*1.5",    32'h3FC00000, 32'h3FC00000, 4'd1, 32'h40100000);
    run("R5 -2*3",       32'hC0000000, 32'h40400000, 4'd1, 32'hC0C00000);
    run("R5 truncation", 32'h3FC00000, 32'h3F800001, 4'd1, 32'h3FC00001);
    run("R5 max frac",   32'h3FFFFFFF, 32'h3FFFFFFF, 4'd1, 32'h407FFFFE);
    run("R6 overflow",   32'h7F000000, 32'h40000000, 4'd1, 32'h7F800000);
    run("R6 underflow",  32'h00800000, 32'h3F000000, 4'd1, 32'h00000000);
    run("R6 neg under",  32'h80800000, 32'h3F000000, 4'd1, 32'h80000000);
    run("R7 zero",       32'h00000000, 32'hC0000000, 4'd1, 32'h80000000);
    run("R7 subnormal",  32'h00000001, 32'h40000000, 4'd1, 32'h00000000);
    run("R8 inf",        32'h7F800000, 32'hC0000000, 4'd1, 32'hFF800000);
    run("R8 inf*inf",    32'hFF800000, 32'hFF800000, 4'd1, 32'h7F800000);
    run("R9 zero*inf",   32'h00000000, 32'h7F800000, 4'd1, QN);
    run("R9 nan",        32'h7F800001, 32'h3F800000, 4'd1, QN);
    run("R10 bad op",    32'h40000000, 32'h40400000, 4'd2, QN);

    // R1: write to result address has no effect
    wr(2'd3, 32'hDEADBEEF); rd(2'd3, r); chk("R1 result write ignored", r, QN);

    // R11, R12, R13 during one busy window
    cur_req = "R11";
    wr(2'd0, 32'h40000000); wr(2'd1, 32'h40800000); wr(2'd2, 32'h1);
    rd(2'd2, r); chk("R3 ready cleared", r, 32'h0);
    rd(2'd3, r); chk("R12 stale result", r, QN);
    wr(2'd0, 32'h3F800000);
    rd(2'd0, r); chk("R13 A readback during busy", r, 32'h3F800000);
    wr(2'd2, 32'h2);
    n = 5;
    begin
      logic [31:0] s;
      do begin rd(2'd2, s); n++; end while (s[0] == 0 && n < 200);
    end
    chk("R11 latency unchanged", 32'(n), 32'(LATC + 1));
    rd(2'd3, r); chk("R13 captured operands", r, 32'h41000000);
    chk("R11 busy cmd ignored", r, 32'h41000000);

    cur_req = "R5";
    run("R5 new operand", 32'h3F800000, 32'h40800000, 4'd1, 32'h40800000);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule